// File: doc/BRIEF.md
# GPIO Register Interface

This block is the software-facing register slave of a 32-pin general-purpose I/O port. It stores the output data, the per-pin direction, the interrupt mask, two banks of 2-bit interrupt sensitivity codes and an optional per-pin any-edge enable. It drives the pin outputs and output enables. It passes its configuration to a separate interrupt detector and shows that detector's sampled pin levels and interrupt status back to software.

Requests arrive on a simple valid/write/address/strobe/data port. Every request gets a response exactly one cycle later. Reads of the data word mix two sources: output pins report the value being driven and input pins report the sampled level. Writes that change how the detector should judge the current pin levels raise a one-cycle re-evaluate pulse. A write to the status word sends a one-cycle clear pulse carrying the bits to clear. The status bits themselves live in the detector.

Top module: `gpio_regif`

## Requirements
- R1: After reset every stored register is 0. All pins are therefore inputs (`pin_oe` = 0, `pin_out` = 0), `sense_cfg`, `irq_mask` and `any_edge_en` are 0, and `rsp_valid`, `status_clr` and `reeval` are low.
- R2: A write to offset 0x04 sets the direction word, where bit i = 1 makes pin i an output, and a write to offset 0x00 sets the data word. From the cycle after the write, `pin_oe` equals the direction word and `pin_out` equals data AND direction. A pin with direction 0 is driven 0 whatever its data bit holds.
- R3: A read of offset 0x00 returns (data AND direction) OR (`pin_level` AND NOT direction). `pin_level` is sampled in the request cycle.
- R4: A read of offset 0x08 returns `pin_level` with the bits of output pins forced to 0. A write to 0x08 changes nothing.
- R5: Offset 0x0C holds the 2-bit sensitivity codes of pins 0–15, pin i at bits 2i+1:2i. Offset 0x10 holds the codes of pins 16–31, pin 16+i at bits 2i+1:2i. `sense_cfg` is {0x10 word, 0x0C word}, and both words read back as written.
- R6: Offset 0x14 is the interrupt mask. It reads back as written and drives `irq_mask`.
- R7: A read of offset 0x18 returns `irq_status` as sampled in the request cycle. A write to 0x18 stores nothing. In the next cycle it raises `status_clr` for one cycle, with `status_clr_bits` equal to the written data. Outside such a pulse `status_clr_bits` is 0.
- R8: With HAS_ANY_EDGE = 1, offset 0x1C is the any-edge enable word, reads back as written and drives `any_edge_en`. With HAS_ANY_EDGE = 0, 0x1C reads 0, writes are ignored and `any_edge_en` stays 0.
- R9: A request to an offset outside 0x00–0x1C, or with address bits 1:0 not zero, reads 0 and changes no register.
- R10: A request whose `req_strb` is not all ones reads 0 and changes no register.
- R11: `reeval` pulses for one cycle, the cycle after an accepted write to 0x04, 0x0C, 0x10, 0x18 or (when present) 0x1C. Writes to 0x00, 0x08 and 0x14 do not pulse it.
- R12: `rsp_valid` is high exactly in the cycle after each cycle with `req_valid` high. `rsp_rdata` carries the read value for reads and 0 for writes and for idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte offset of the register |
| req_strb | input | DATA_W/8 (4) | Byte lanes; only all ones is a valid access |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | DATA_W (32) | Read data, 0 for writes |
| pin_level | input | DATA_W (32) | Sampled pin levels from the detector |
| irq_status | input | DATA_W (32) | Interrupt status bits held by the detector |
| pin_out | output | DATA_W (32) | Pin output values |
| pin_oe | output | DATA_W (32) | Pin output enables, also the direction for the detector |
| sense_cfg | output | 2*DATA_W (64) | 2-bit sensitivity code per pin |
| irq_mask | output | DATA_W (32) | Interrupt enable per pin |
| any_edge_en | output | DATA_W (32) | Any-edge enable per pin |
| status_clr | output | 1 | One-cycle status clear pulse |
| status_clr_bits | output | DATA_W (32) | Status bits to clear during the pulse |
| reeval | output | 1 | One-cycle re-evaluate pulse to the detector |

## Verification
The data-word read is tried with direction patterns that split the word into output and input halves, with all outputs, and with all inputs. Each pattern is combined with pin levels that differ from the data bits, so a read that takes the wrong source for any pin gives a visible mismatch. Writes with partial strobes, misaligned offsets, offsets above the map and the read-only pin-state offset are each followed by read-backs, which separate a dropped write from a stray one. A long run of back-to-back random requests, with the detector inputs changing every cycle, checks the response timing, both pulses and every configuration output against a reference model on each clock. A second instance built without the any-edge word sees the same stimulus.

// File: rtl/gpio_regif_pkg.sv
package gpio_regif_pkg;
  localparam int REG_CNT    = 8;
  localparam int IDX_W      = $clog2(REG_CNT);
  localparam int RI_DATA    = 0;
  localparam int RI_DIR     = 1;
  localparam int RI_STATE   = 2;
  localparam int RI_SENS_LO = 3;
  localparam int RI_SENS_HI = 4;
  localparam int RI_MASK    = 5;
  localparam int RI_STATUS  = 6;
  localparam int RI_ANYEDGE = 7;
endpackage

// File: rtl/gpio_regif_decode.sv
module gpio_regif_decode
  import gpio_regif_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int STRB_W       = 4,
  parameter bit HAS_ANY_EDGE = 1'b1
) (
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [STRB_W-1:0]  req_strb,
  output logic [REG_CNT-1:0] wr_sel,
  output logic [REG_CNT-1:0] rd_sel
);
  localparam int WORD_LSB = $clog2(STRB_W);
  localparam int WORD_W   = ADDR_W - WORD_LSB;
  localparam int LAST_IDX = HAS_ANY_EDGE ? REG_CNT - 1 : REG_CNT - 2;
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(LAST_IDX);

  logic [WORD_W-1:0]  word;
  logic               aligned;
  logic               full_width;
  logic               in_range;
  logic               hit;
  logic [REG_CNT-1:0] onehot;

  always_comb begin
    word       = req_addr[ADDR_W-1:WORD_LSB];
    aligned    = (req_addr[WORD_LSB-1:0] == '0);
    full_width = &req_strb;
    in_range   = (word <= LAST_WORD);
    hit        = req_valid && aligned && full_width && in_range;
    onehot     = '0;
    if (hit) begin
      onehot[word[IDX_W-1:0]] = 1'b1;
    end
    wr_sel = req_write ? onehot : '0;
    rd_sel = req_write ? '0 : onehot;
  end
endmodule

// File: rtl/gpio_regif_cfg.sv
module gpio_regif_cfg
  import gpio_regif_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter bit HAS_ANY_EDGE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REG_CNT-1:0] wr_sel,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  data_q,
  output logic [DATA_W-1:0]  dir_q,
  output logic [DATA_W-1:0]  sens_lo_q,
  output logic [DATA_W-1:0]  sens_hi_q,
  output logic [DATA_W-1:0]  mask_q,
  output logic [DATA_W-1:0]  edge_q,
  output logic               clr_q,
  output logic [DATA_W-1:0]  clr_bits_q,
  output logic               reeval_q
);
  logic [DATA_W-1:0] data_d, dir_d, sens_lo_d, sens_hi_d, mask_d;
  logic [DATA_W-1:0] clr_bits_d;
  logic              clr_d, reeval_d;

  always_comb begin
    data_d     = wr_sel[RI_DATA]    ? wdata : data_q;
    dir_d      = wr_sel[RI_DIR]     ? wdata : dir_q;
    sens_lo_d  = wr_sel[RI_SENS_LO] ? wdata : sens_lo_q;
    sens_hi_d  = wr_sel[RI_SENS_HI] ? wdata : sens_hi_q;
    mask_d     = wr_sel[RI_MASK]    ? wdata : mask_q;
    clr_d      = wr_sel[RI_STATUS];
    clr_bits_d = wr_sel[RI_STATUS]  ? wdata : '0;
    reeval_d   = wr_sel[RI_DIR] | wr_sel[RI_SENS_LO] | wr_sel[RI_SENS_HI]
               | wr_sel[RI_STATUS] | wr_sel[RI_ANYEDGE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q     <= '0;
      dir_q      <= '0;
      sens_lo_q  <= '0;
      sens_hi_q  <= '0;
      mask_q     <= '0;
      clr_q      <= 1'b0;
      clr_bits_q <= '0;
      reeval_q   <= 1'b0;
    end else begin
      data_q     <= data_d;
      dir_q      <= dir_d;
      sens_lo_q  <= sens_lo_d;
      sens_hi_q  <= sens_hi_d;
      mask_q     <= mask_d;
      clr_q      <= clr_d;
      clr_bits_q <= clr_bits_d;
      reeval_q   <= reeval_d;
    end
  end

  generate
    if (HAS_ANY_EDGE) begin : g_edge
      logic [DATA_W-1:0] edge_d;
      always_comb edge_d = wr_sel[RI_ANYEDGE] ? wdata : edge_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= edge_d;
      end
    end else begin : g_no_edge
      assign edge_q = '0;
    end
  endgenerate

  // R2: direction only moves on a direction write
  p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel[RI_DIR] |=> $stable(dir_q));
  // R6: mask only moves on a mask write
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel[RI_MASK] |=> $stable(mask_q));
  // R7: clear bits are quiet outside a clear pulse
  p_clr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_q |-> (clr_bits_q == '0));
  // R11: a pin-state write raises no re-evaluate pulse
  p_state_no_reeval_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel[RI_STATE] |=> !reeval_q);
endmodule

// File: rtl/gpio_regif_rdmux.sv
module gpio_regif_rdmux
  import gpio_regif_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [REG_CNT-1:0] rd_sel,
  input  logic [DATA_W-1:0]  data_q,
  input  logic [DATA_W-1:0]  dir_q,
  input  logic [DATA_W-1:0]  sens_lo_q,
  input  logic [DATA_W-1:0]  sens_hi_q,
  input  logic [DATA_W-1:0]  mask_q,
  input  logic [DATA_W-1:0]  edge_q,
  input  logic [DATA_W-1:0]  pin_level,
  input  logic [DATA_W-1:0]  irq_status,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata
);
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (rd_sel[RI_DATA])    rd_val = rd_val | (data_q & dir_q) | (pin_level & ~dir_q);
    if (rd_sel[RI_DIR])     rd_val = rd_val | dir_q;
    if (rd_sel[RI_STATE])   rd_val = rd_val | (pin_level & ~dir_q);
    if (rd_sel[RI_SENS_LO]) rd_val = rd_val | sens_lo_q;
    if (rd_sel[RI_SENS_HI]) rd_val = rd_val | sens_hi_q;
    if (rd_sel[RI_MASK])    rd_val = rd_val | mask_q;
    if (rd_sel[RI_STATUS])  rd_val = rd_val | irq_status;
    if (rd_sel[RI_ANYEDGE]) rd_val = rd_val | edge_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd_val;
    end
  end

  // R12: every request gets a response the next cycle
  p_rsp_follows_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R12: no response without a request
  p_rsp_needs_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));
  // R12: idle cycles carry zero data
  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_rdata == '0));
endmodule

// File: rtl/gpio_regif.sv
module gpio_regif
  import gpio_regif_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 8,
  parameter bit HAS_ANY_EDGE = 1'b1,
  localparam int STRB_W      = DATA_W / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [STRB_W-1:0]   req_strb,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  input  logic [DATA_W-1:0]   pin_level,
  input  logic [DATA_W-1:0]   irq_status,
  output logic [DATA_W-1:0]   pin_out,
  output logic [DATA_W-1:0]   pin_oe,
  output logic [2*DATA_W-1:0] sense_cfg,
  output logic [DATA_W-1:0]   irq_mask,
  output logic [DATA_W-1:0]   any_edge_en,
  output logic                status_clr,
  output logic [DATA_W-1:0]   status_clr_bits,
  output logic                reeval
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [REG_CNT-1:0] wr_sel, rd_sel;
  logic [DATA_W-1:0]  data_q, dir_q, sens_lo_q, sens_hi_q, mask_q, edge_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  gpio_regif_decode #(
    .ADDR_W(ADDR_W), .STRB_W(STRB_W), .HAS_ANY_EDGE(HAS_ANY_EDGE)
  ) u_decode (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_strb(req_strb), .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  gpio_regif_cfg #(
    .DATA_W(DATA_W), .HAS_ANY_EDGE(HAS_ANY_EDGE)
  ) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .wr_sel(wr_sel), .wdata(req_wdata),
    .data_q(data_q), .dir_q(dir_q), .sens_lo_q(sens_lo_q), .sens_hi_q(sens_hi_q),
    .mask_q(mask_q), .edge_q(edge_q), .clr_q(status_clr),
    .clr_bits_q(status_clr_bits), .reeval_q(reeval)
  );

  gpio_regif_rdmux #(
    .DATA_W(DATA_W)
  ) u_rdmux (
    .clk(clk), .rst_n(rst_int_n), .req_valid(req_valid), .rd_sel(rd_sel),
    .data_q(data_q), .dir_q(dir_q), .sens_lo_q(sens_lo_q), .sens_hi_q(sens_hi_q),
    .mask_q(mask_q), .edge_q(edge_q), .pin_level(pin_level),
    .irq_status(irq_status), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign pin_oe      = dir_q;
  assign pin_out     = data_q & dir_q;
  assign sense_cfg   = {sens_hi_q, sens_lo_q};
  assign irq_mask    = mask_q;
  assign any_edge_en = edge_q;

  // R12: a write answers with zero data
  p_write_rsp_zero_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_write) |=> (rsp_rdata == '0));
  // R10: a partial-strobe write leaves the configuration alone
  p_partial_ignored_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_write && !(&req_strb)) |=>
      ($stable(pin_oe) && $stable(pin_out) && $stable(sense_cfg) &&
       $stable(irq_mask) && $stable(any_edge_en)));
  // R7: a clear pulse only follows a write
  p_clr_after_write_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    status_clr |-> $past(req_valid && req_write));
  // R11: a re-evaluate pulse only follows a write
  p_reeval_after_write_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    reeval |-> $past(req_valid && req_write));
endmodule

// File: tb/tb_gpio_regif.sv
module tb_gpio_regif;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [3:0]  req_strb = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] pin_level = '0;
  logic [31:0] irq_status = '0;

  logic        rsp_valid, status_clr, reeval;
  logic [31:0] rsp_rdata, pin_out, pin_oe, irq_mask, any_edge_en, status_clr_bits;
  logic [63:0] sense_cfg;

  logic        ne_rsp_valid, ne_status_clr, ne_reeval;
  logic [31:0] ne_rsp_rdata, ne_pin_out, ne_pin_oe, ne_irq_mask, ne_any_edge_en, ne_clr_bits;
  logic [63:0] ne_sense_cfg;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_regif dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_strb(req_strb), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pin_level(pin_level),
    .irq_status(irq_status), .pin_out(pin_out), .pin_oe(pin_oe),
    .sense_cfg(sense_cfg), .irq_mask(irq_mask), .any_edge_en(any_edge_en),
    .status_clr(status_clr), .status_clr_bits(status_clr_bits), .reeval(reeval)
  );

  gpio_regif #(.HAS_ANY_EDGE(1'b0)) dut_ne (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_strb(req_strb), .req_wdata(req_wdata),
    .rsp_valid(ne_rsp_valid), .rsp_rdata(ne_rsp_rdata), .pin_level(pin_level),
    .irq_status(irq_status), .pin_out(ne_pin_out), .pin_oe(ne_pin_oe),
    .sense_cfg(ne_sense_cfg), .irq_mask(ne_irq_mask), .any_edge_en(ne_any_edge_en),
    .status_clr(ne_status_clr), .status_clr_bits(ne_clr_bits), .reeval(ne_reeval)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_data, m_dir, m_slo, m_shi, m_mask, m_edge, m_rsp_d, m_clrb;
  bit          m_rsp_v, m_clr, m_reeval, ne_rd_edge, ne_wr_edge;
  string       m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = 0; m_dir = 0; m_slo = 0; m_shi = 0; m_mask = 0; m_edge = 0;
      m_rsp_v = 0; m_rsp_d = 0; m_clr = 0; m_clrb = 0; m_reeval = 0;
      ne_rd_edge = 0; ne_wr_edge = 0; m_tag = "R12";
    end else begin
      int idx;
      bit hit;
      m_clr = 0; m_clrb = 0; m_reeval = 0; m_rsp_d = 0;
      m_rsp_v = req_valid;
      ne_rd_edge = 0; ne_wr_edge = 0;
      if (req_valid) begin
        hit = (req_strb == 4'hF) && (req_addr[1:0] == 2'b00) && (req_addr < 8'h20);
        idx = int'(req_addr) / 4;
        ne_rd_edge = hit && !req_write && idx == 7;
        ne_wr_edge = hit && req_write && idx == 7;
        if (req_strb != 4'hF) m_tag = "R10";
        else if (!hit) m_tag = "R9";
        else if (req_write) m_tag = "R12";
        else begin
          case (idx)
            0: begin m_tag = "R3"; m_rsp_d = (m_data & m_dir) | (pin_level & ~m_dir); end
            1: begin m_tag = "R2"; m_rsp_d = m_dir; end
            2: begin m_tag = "R4"; m_rsp_d = pin_level & ~m_dir; end
            3: begin m_tag = "R5"; m_rsp_d = m_slo; end
            4: begin m_tag = "R5"; m_rsp_d = m_shi; end
            5: begin m_tag = "R6"; m_rsp_d = m_mask; end
            6: begin m_tag = "R7"; m_rsp_d = irq_status; end
            default: begin m_tag = "R8"; m_rsp_d = m_edge; end
          endcase
        end
        if (hit && req_write) begin
          case (idx)
            0: m_data = req_wdata;
            1: begin m_dir = req_wdata; m_reeval = 1; end
            3: begin m_slo = req_wdata; m_reeval = 1; end
            4: begin m_shi = req_wdata; m_reeval = 1; end
            5: m_mask = req_wdata;
            6: begin m_clr = 1; m_clrb = req_wdata; m_reeval = 1; end
            7: begin m_edge = req_wdata; m_reeval = 1; end
            default: ;
          endcase
        end
      end
    end
  end

  // Per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 pin_oe", {32'h0, pin_oe}, {32'h0, m_dir});
      chk("R2 pin_out", {32'h0, pin_out}, {32'h0, m_data & m_dir});
      chk("R5 sense_cfg", sense_cfg, {m_shi, m_slo});
      chk("R6 irq_mask", {32'h0, irq_mask}, {32'h0, m_mask});
      chk("R8 any_edge_en", {32'h0, any_edge_en}, {32'h0, m_edge});
      chk("R7 status_clr", {63'h0, status_clr}, {63'h0, m_clr});
      chk("R7 status_clr_bits", {32'h0, status_clr_bits}, {32'h0, m_clrb});
      chk("R11 reeval", {63'h0, reeval}, {63'h0, m_reeval});
      chk("R12 rsp_valid", {63'h0, rsp_valid}, {63'h0, m_rsp_v});
      chk({m_tag, " rsp_rdata"}, {32'h0, rsp_rdata}, {32'h0, m_rsp_d});
      chk("R8 no-edge any_edge_en", {32'h0, ne_any_edge_en}, 64'h0);
      if (ne_rd_edge) chk("R8 no-edge read", {32'h0, ne_rsp_rdata}, 64'h0);
      if (ne_wr_edge) chk("R8 no-edge reeval", {63'h0, ne_reeval}, 64'h0);
    end
  end

  logic [31:0] rd_d, ne_rd_d;
  bit          s_reeval, s_clr, s_rspv;
  logic [31:0] s_clrb;

  task automatic xfer(input bit w, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] s);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_strb = s;
    @(negedge clk);
    rd_d = rsp_rdata; ne_rd_d = ne_rsp_rdata; s_rspv = rsp_valid;
    s_reeval = reeval; s_clr = status_clr; s_clrb = status_clr_bits;
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; req_strb = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    xfer(1'b1, a, d, 4'hF);
  endtask

  task automatic rd(input logic [7:0] a);
    xfer(1'b0, a, 32'h0, 4'hF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 pin_oe", {32'h0, pin_oe}, 0);
    chk("R1 pin_out", {32'h0, pin_out}, 0);
    chk("R1 sense_cfg", sense_cfg, 0);
    chk("R1 irq_mask", {32'h0, irq_mask}, 0);
    chk("R1 any_edge_en", {32'h0, any_edge_en}, 0);
    chk("R1 pulses", {61'h0, rsp_valid, status_clr, reeval}, 0);

    // R2 direction and data drive pins
    wr(8'h04, 32'h0000FFFF);
    chk("R11 reeval after dir write", {63'h0, s_reeval}, 1);
    wr(8'h00, 32'hA5A5A5A5);
    chk("R11 no reeval after data write", {63'h0, s_reeval}, 0);
    chk("R2 pin_oe", {32'h0, pin_oe}, 64'h0000FFFF);
    chk("R2 pin_out", {32'h0, pin_out}, 64'h0000A5A5);
    chk("R12 write response", {31'h0, s_rspv, rd_d}, {31'h0, 1'b1, 32'h0});

    // R3 / R4 mixed read and masked pin state
    pin_level = 32'h3C3C3C3C;
    rd(8'h00); chk("R3 data read split", {32'h0, rd_d}, 64'h3C3CA5A5);
    rd(8'h08); chk("R4 pin state split", {32'h0, rd_d}, 64'h3C3C0000);
    wr(8'h08, 32'hFFFFFFFF);
    chk("R11 no reeval after state write", {63'h0, s_reeval}, 0);
    rd(8'h08); chk("R4 state write ignored", {32'h0, rd_d}, 64'h3C3C0000);
    wr(8'h04, 32'hFFFFFFFF);
    rd(8'h00); chk("R3 data read all out", {32'h0, rd_d}, 64'hA5A5A5A5);
    rd(8'h08); chk("R4 pin state all out", {32'h0, rd_d}, 0);
    wr(8'h04, 32'h0);
    chk("R2 pin_out all in", {32'h0, pin_out}, 0);
    rd(8'h00); chk("R3 data read all in", {32'h0, rd_d}, 64'h3C3C3C3C);

    // R5 sensitivity banks
    wr(8'h0C, 32'h11223344);
    chk("R11 reeval after low sense", {63'h0, s_reeval}, 1);
    wr(8'h10, 32'h55667788);
    chk("R11 reeval after high sense", {63'h0, s_reeval}, 1);
    chk("R5 sense_cfg", sense_cfg, 64'h55667788_11223344);
    rd(8'h0C); chk("R5 low readback", {32'h0, rd_d}, 64'h11223344);
    rd(8'h10); chk("R5 high readback", {32'h0, rd_d}, 64'h55667788);

    // R6 mask
    wr(8'h14, 32'hF0F0000F);
    chk("R11 no reeval after mask", {63'h0, s_reeval}, 0);
    rd(8'h14); chk("R6 mask readback", {32'h0, rd_d}, 64'hF0F0000F);
    chk("R6 irq_mask", {32'h0, irq_mask}, 64'hF0F0000F);

    // R7 status read and clear pulse
    irq_status = 32'hDEADBEEF;
    rd(8'h18); chk("R7 status read", {32'h0, rd_d}, 64'hDEADBEEF);
    wr(8'h18, 32'h0000FF00);
    chk("R7 clear pulse", {63'h0, s_clr}, 1);
    chk("R7 clear bits", {32'h0, s_clrb}, 64'h0000FF00);
    chk("R11 reeval after status", {63'h0, s_reeval}, 1);
    @(negedge clk);
    chk("R7 clear pulse one cycle", {31'h0, status_clr, status_clr_bits}, 0);

    // R8 any-edge word, present and absent
    wr(8'h1C, 32'h12345678);
    chk("R11 reeval after any-edge", {63'h0, s_reeval}, 1);
    rd(8'h1C);
    chk("R8 any-edge readback", {32'h0, rd_d}, 64'h12345678);
    chk("R8 no-edge read zero", {32'h0, ne_rd_d}, 0);
    chk("R8 any_edge_en", {32'h0, any_edge_en}, 64'h12345678);

    // R9 undefined and misaligned offsets
    wr(8'h04, 32'h0000FFFF);
    wr(8'h20, 32'hFFFFFFFF);
    wr(8'h06, 32'hFFFFFFFF);
    wr(8'hFC, 32'hFFFFFFFF);
    chk("R9 no reeval on undefined", {63'h0, s_reeval}, 0);
    rd(8'h04); chk("R9 dir unchanged", {32'h0, rd_d}, 64'h0000FFFF);
    rd(8'h20); chk("R9 undefined read", {32'h0, rd_d}, 0);
    rd(8'h15); chk("R9 misaligned read", {32'h0, rd_d}, 0);

    // R10 partial strobes
    xfer(1'b1, 8'h04, 32'hFFFFFFFF, 4'h3);
    chk("R10 no reeval on partial", {63'h0, s_reeval}, 0);
    rd(8'h04); chk("R10 dir unchanged", {32'h0, rd_d}, 64'h0000FFFF);
    xfer(1'b0, 8'h14, 32'h0, 4'h1);
    chk("R10 partial read zero", {32'h0, rd_d}, 0);
    chk("R12 response on partial", {63'h0, s_rspv}, 1);
    @(negedge clk);
    chk("R12 idle after response", {63'h0, rsp_valid}, 0);

    // Back-to-back random traffic checked every clock by the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      req_valid  = ($urandom_range(0, 3) != 0);
      req_write  = $urandom_range(0, 1);
      req_addr   = ($urandom_range(0, 9) == 0) ? 8'($urandom_range(0, 255))
                                               : 8'($urandom_range(0, 8) * 4);
      req_strb   = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'hF;
      req_wdata  = $urandom;
      pin_level  = $urandom;
      irq_status = $urandom;
    end
    @(negedge clk);
    req_valid = 0; req_write = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule